// File: doc/BRIEF.md
# Dual LIN transceiver mode controller

This block holds the digital control for two LIN physical-layer channels that share one power-on reset. Each channel takes a sleep-control input, a transmit-data input and a sampled bus level. It returns a receive-data output and an enable for its transmit driver. Each channel runs its own mode machine with three states: Sleep, Standby and Normal. A single Reset state, entered on power-on reset or on low supply, covers both channels at once.

Sleep-control transitions are time-qualified by run-length filters. A remote wake-up is accepted only after a filtered dominant bus level seen in Sleep. The resulting wake request is reported by pulling the receive output low outside Normal. The transmit driver is kept off if the transmit input is already dominant when the channel enters Normal. It is also cut off when the transmit input stays dominant too long. All windows are parameters counted in clock cycles. Undervoltage and over-temperature arrive as digital status inputs.

Top module: `lin_dual_mode_ctrl`

## Requirements
- R1: While rst_ni is low, and after any clock edge at which undervolt_i is high, every channel is in Reset (mode code 2'b00) with tx_en_o low, rxd_o high and its wake flag cleared. At the first edge with rst_ni high and undervolt_i low, a channel in Reset moves to Standby (code 2'b10). Mode codes are Sleep 2'b01 and Normal 2'b11, and channel c uses bits mode_o[2c+1:2c].
- R2: A channel in Standby or Sleep moves to Normal at the clock edge where slp_n_i has been sampled high on GO_NORM_CYC consecutive edges. One sample fewer leaves the mode unchanged.
- R3: A channel in Normal moves to Sleep at the clock edge where slp_n_i has been sampled low on GO_SLEEP_CYC consecutive edges.
- R4: The channels change mode independently. A transition on one channel leaves the mode of the other unchanged.
- R5: In Normal, rxd_o equals bus_i in the same cycle (1 recessive, 0 dominant).
- R6: A channel in Sleep whose bus_i is sampled low on WAKE_FILT_CYC consecutive edges moves to Standby and sets its wake flag. A shorter dominant run has no effect. Outside Normal, rxd_o is low exactly while the wake flag is set.
- R7: The wake flag is cleared when slp_n_i brings the channel to Normal. A local wake from Sleep goes straight to Normal with the flag clear. If both wake conditions complete at the same edge, the local one wins.
- R8: On entry to Normal, tx_en_o goes high only if txd_i was high at the entry edge. Otherwise the driver stays off until an edge samples txd_i high.
- R9: In Normal, if txd_i is sampled low on DOM_TO_CYC consecutive edges, tx_en_o drops after that edge. It returns only after an edge that samples txd_i high.
- R10: tx_en_o is low in every mode other than Normal.
- R11: overtemp_i forces tx_en_o low in the same cycle and has no effect on the modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset, shared |
| undervolt_i | input | 1 | Supply-low status; holds both channels in Reset |
| overtemp_i | input | 1 | Over-temperature status; disables all drivers |
| slp_n_i | input | NUM_CH | Per-channel sleep control, active low |
| txd_i | input | NUM_CH | Per-channel transmit data, 0 dominant |
| bus_i | input | NUM_CH | Per-channel sampled bus level, 0 dominant |
| rxd_o | output | NUM_CH | Per-channel receive data or wake request |
| tx_en_o | output | NUM_CH | Per-channel transmit driver enable |
| mode_o | output | 2*NUM_CH | Per-channel mode code |

## Verification
Properties checked on every cycle:
- Reset is held after any undervoltage edge.
- Sleep is entered only from Normal with the sleep input low.
- The wake flag rises only from Sleep on a dominant bus.
- The driver cannot come on at a Normal entry with the transmit input dominant.
- The driver is re-enabled only after a recessive transmit sample.

Scenarios on the bench show what needs a time window:
- The exact edge at which each filtered transition completes, and that one sample fewer does nothing.
- A short dominant pulse in Sleep being ignored.
- The dominant timeout cutting the driver.
- The local wake winning a tie with the remote wake.
- The independence of the two channels.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RESET   = 2'b00,
    MODE_SLEEP   = 2'b01,
    MODE_STANDBY = 2'b10,
    MODE_NORMAL  = 2'b11
  } lin_mode_e;
endpackage

// File: rtl/lin_run_cnt.sv
// Consecutive-sample qualifier: hit_o when lvl_i is high on the LIMIT-th edge in a row.
module lin_run_cnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic lvl_i,
  output logic hit_o
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !lvl_i)   cnt_q <= '0;
    else if (cnt_q != TOP)      cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = lvl_i && (cnt_q >= TOP);
endmodule

// File: rtl/lin_chan_fsm.sv
module lin_chan_fsm
  import lin_mode_pkg::*;
#(
  parameter int unsigned GO_NORM_CYC   = 4,
  parameter int unsigned GO_SLEEP_CYC  = 6,
  parameter int unsigned WAKE_FILT_CYC = 5,
  parameter int unsigned DOM_TO_CYC    = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hold_i,
  input  logic      otp_i,
  input  logic      slp_n_i,
  input  logic      txd_i,
  input  logic      bus_i,
  output lin_mode_e mode_o,
  output logic      rxd_o,
  output logic      tx_en_o
);
  lin_mode_e mode_q, mode_d;
  logic wake_q, wake_d;
  logic tx_ok_q, tx_ok_d;
  logic in_rst;
  logic norm_hit, sleep_hit, wake_hit, dom_hit;

  assign in_rst = hold_i || (mode_q == MODE_RESET);

  lin_run_cnt #(.LIMIT(GO_NORM_CYC)) i_norm_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(in_rst), .lvl_i(slp_n_i), .hit_o(norm_hit));

  lin_run_cnt #(.LIMIT(GO_SLEEP_CYC)) i_sleep_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(in_rst), .lvl_i(!slp_n_i), .hit_o(sleep_hit));

  lin_run_cnt #(.LIMIT(WAKE_FILT_CYC)) i_wake_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(mode_q != MODE_SLEEP), .lvl_i(!bus_i),
    .hit_o(wake_hit));

  lin_run_cnt #(.LIMIT(DOM_TO_CYC)) i_dom_flt (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(mode_q != MODE_NORMAL), .lvl_i(!txd_i),
    .hit_o(dom_hit));

  always_comb begin
    mode_d  = mode_q;
    wake_d  = wake_q;
    tx_ok_d = tx_ok_q;
    unique case (mode_q)
      MODE_RESET: begin
        mode_d = MODE_STANDBY;
        wake_d = 1'b0;
      end
      MODE_STANDBY: if (norm_hit) mode_d = MODE_NORMAL;
      MODE_SLEEP: begin
        if (norm_hit) mode_d = MODE_NORMAL;       // local wake has priority
        else if (wake_hit) begin
          mode_d = MODE_STANDBY;
          wake_d = 1'b1;
        end
      end
      MODE_NORMAL: if (sleep_hit) mode_d = MODE_SLEEP;
      default: mode_d = MODE_RESET;
    endcase

    if (mode_d == MODE_NORMAL) begin
      if (mode_q != MODE_NORMAL) begin
        wake_d  = 1'b0;
        tx_ok_d = txd_i;                          // entry dominant check
      end else if (txd_i) begin
        tx_ok_d = 1'b1;
      end else if (dom_hit) begin
        tx_ok_d = 1'b0;                           // dominant timeout
      end
    end else begin
      tx_ok_d = 1'b0;
    end

    if (hold_i) begin
      mode_d  = MODE_RESET;
      wake_d  = 1'b0;
      tx_ok_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_RESET;
      wake_q  <= 1'b0;
      tx_ok_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      wake_q  <= wake_d;
      tx_ok_q <= tx_ok_d;
    end
  end

  assign mode_o  = mode_q;
  assign rxd_o   = (mode_q == MODE_NORMAL) ? bus_i : !wake_q;
  assign tx_en_o = tx_ok_q && (mode_q == MODE_NORMAL) && !otp_i;

  assert_hold_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (mode_q == MODE_RESET) && !tx_en_o && !wake_q);

  assert_sleep_from_normal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SLEEP && $past(mode_q) != MODE_SLEEP)
      |-> ($past(mode_q) == MODE_NORMAL && !$past(slp_n_i)));

  assert_wake_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_q) |-> ($past(mode_q) == MODE_SLEEP && !$past(bus_i)));

  assert_entry_check_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_NORMAL && !txd_i) |=> !tx_en_o);

  assert_reenable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_NORMAL && $past(mode_q) == MODE_NORMAL && $rose(tx_ok_q))
      |-> $past(txd_i));
endmodule

// File: rtl/lin_dual_mode_ctrl.sv
module lin_dual_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int unsigned NUM_CH        = 2,
  parameter int unsigned GO_NORM_CYC   = 4,
  parameter int unsigned GO_SLEEP_CYC  = 6,
  parameter int unsigned WAKE_FILT_CYC = 5,
  parameter int unsigned DOM_TO_CYC    = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  undervolt_i,
  input  logic                  overtemp_i,
  input  logic [NUM_CH-1:0]     slp_n_i,
  input  logic [NUM_CH-1:0]     txd_i,
  input  logic [NUM_CH-1:0]     bus_i,
  output logic [NUM_CH-1:0]     rxd_o,
  output logic [NUM_CH-1:0]     tx_en_o,
  output logic [2*NUM_CH-1:0]   mode_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    lin_mode_e mode_c;

    lin_chan_fsm #(
      .GO_NORM_CYC  (GO_NORM_CYC),
      .GO_SLEEP_CYC (GO_SLEEP_CYC),
      .WAKE_FILT_CYC(WAKE_FILT_CYC),
      .DOM_TO_CYC   (DOM_TO_CYC)
    ) i_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hold_i (undervolt_i),     // shared Reset for all channels
      .otp_i  (overtemp_i),
      .slp_n_i(slp_n_i[c]),
      .txd_i  (txd_i[c]),
      .bus_i  (bus_i[c]),
      .mode_o (mode_c),
      .rxd_o  (rxd_o[c]),
      .tx_en_o(tx_en_o[c])
    );

    assign mode_o[2*c +: 2] = mode_c;
  end
endmodule

// File: tb/test_lin_dual_mode_ctrl.sv
module test_lin_dual_mode_ctrl;
  localparam int GN = 4, GS = 6, WF = 5, DT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic uv = 1'b0, ot = 1'b0;
  logic [1:0] slp_n = 2'b00, txd = 2'b11, bus = 2'b11;
  logic [1:0] rxd, txen;
  logic [3:0] mode;

  int checks = 0, fails = 0;
  int m[2], hi[2], lo[2], bd[2], td[2];
  bit wk[2], ok[2];

  always #2.5 clk = ~clk;

  lin_dual_mode_ctrl #(
    .NUM_CH(2), .GO_NORM_CYC(GN), .GO_SLEEP_CYC(GS), .WAKE_FILT_CYC(WF), .DOM_TO_CYC(DT)
  ) i_lin_dual_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .undervolt_i(uv), .overtemp_i(ot),
    .slp_n_i(slp_n), .txd_i(txd), .bus_i(bus),
    .rxd_o(rxd), .tx_en_o(txen), .mode_o(mode)
  );

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic model_clear(input int c);
    m[c] = 0; wk[c] = 0; ok[c] = 0; hi[c] = 0; lo[c] = 0; bd[c] = 0; td[c] = 0;
  endtask

  task automatic model_edge();
    for (int c = 0; c < 2; c++) begin
      bit hih, loh, bwh, tdh, inr;
      int nm;
      if (!rst_n || uv) begin
        model_clear(c);
        continue;
      end
      inr = (m[c] == 0);
      hih = slp_n[c] && (hi[c] + 1 >= GN);
      loh = !slp_n[c] && (lo[c] + 1 >= GS);
      bwh = !bus[c] && (bd[c] + 1 >= WF);
      tdh = !txd[c] && (td[c] + 1 >= DT);
      hi[c] = (inr || !slp_n[c]) ? 0 : hi[c] + 1;
      lo[c] = (inr || slp_n[c]) ? 0 : lo[c] + 1;
      bd[c] = (m[c] != 1 || bus[c]) ? 0 : bd[c] + 1;
      td[c] = (m[c] != 3 || txd[c]) ? 0 : td[c] + 1;
      nm = m[c];
      case (m[c])
        0: begin nm = 2; wk[c] = 0; end
        2: if (hih) nm = 3;
        1: if (hih) nm = 3; else if (bwh) begin nm = 2; wk[c] = 1; end
        3: if (loh) nm = 1;
        default: nm = 0;
      endcase
      if (nm == 3) begin
        if (m[c] != 3) begin wk[c] = 0; ok[c] = txd[c]; end
        else if (txd[c]) ok[c] = 1;
        else if (tdh) ok[c] = 0;
      end else ok[c] = 0;
      m[c] = nm;
    end
  endtask

  task automatic compare();
    for (int c = 0; c < 2; c++) begin
      int erx, etx;
      erx = (m[c] == 3) ? int'(bus[c]) : int'(!wk[c]);
      etx = (ok[c] && m[c] == 3 && !ot) ? 1 : 0;
      chk(int'(mode[2*c +: 2]) == m[c], $sformatf("R2 ch%0d mode", c), mode[2*c +: 2], m[c]);
      chk(int'(rxd[c]) == erx, $sformatf("R5 ch%0d rxd", c), rxd[c], erx);
      chk(int'(txen[c]) == etx, $sformatf("R8 ch%0d tx_en", c), txen[c], etx);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      #1;
      compare();
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_clear(0); model_clear(1);
    step(3);
    chk(mode == 4'b0000, "R1 reset mode", mode, 0);
    chk(txen == 2'b00 && rxd == 2'b11, "R1 reset outputs", {txen, rxd}, 3);
    rst_n = 1'b1;
    step(1);
    chk(mode == 4'b1010, "R1 standby after release", mode, 4'b1010);

    slp_n[0] = 1'b1;
    step(GN - 1);
    chk(mode[1:0] == 2'b10, "R2 short high keeps standby", mode[1:0], 2);
    step(1);
    chk(mode[1:0] == 2'b11, "R2 normal after window", mode[1:0], 3);
    chk(mode[3:2] == 2'b10, "R4 ch1 unchanged", mode[3:2], 2);
    chk(txen[0] == 1'b1, "R8 enabled on clean entry", txen[0], 1);

    bus[0] = 1'b0; step(1);
    chk(rxd[0] == 1'b0, "R5 rxd follows dominant", rxd[0], 0);
    bus[0] = 1'b1; step(1);
    chk(rxd[0] == 1'b1, "R5 rxd follows recessive", rxd[0], 1);

    txd[0] = 1'b0; step(DT - 1);
    chk(txen[0] == 1'b1, "R9 before timeout", txen[0], 1);
    step(1);
    chk(txen[0] == 1'b0, "R9 timeout cuts driver", txen[0], 0);
    step(3);
    chk(txen[0] == 1'b0, "R9 stays off while dominant", txen[0], 0);
    txd[0] = 1'b1; step(1);
    chk(txen[0] == 1'b1, "R9 re-enabled on recessive", txen[0], 1);

    ot = 1'b1; step(1);
    chk(txen[0] == 1'b0 && mode[1:0] == 2'b11, "R11 overtemp", {txen[0], mode[1:0]}, 3);
    ot = 1'b0; step(1);
    chk(txen[0] == 1'b1, "R11 overtemp released", txen[0], 1);

    txd[1] = 1'b0; slp_n[1] = 1'b1; step(GN);
    chk(mode[3:2] == 2'b11 && txen[1] == 1'b0, "R8 dominant at entry", {mode[3:2], txen[1]}, 6);
    txd[1] = 1'b1; step(1);
    chk(txen[1] == 1'b1, "R8 enabled after recessive", txen[1], 1);

    slp_n[0] = 1'b0; step(GS - 1);
    chk(mode[1:0] == 2'b11, "R3 short low keeps normal", mode[1:0], 3);
    step(1);
    chk(mode[1:0] == 2'b01, "R3 sleep after window", mode[1:0], 1);
    chk(txen[0] == 1'b0 && rxd[0] == 1'b1, "R10 sleep outputs", {txen[0], rxd[0]}, 1);
    chk(mode[3:2] == 2'b11, "R4 ch1 stays normal", mode[3:2], 3);

    bus[0] = 1'b0; step(WF - 1);
    bus[0] = 1'b1; step(2);
    chk(mode[1:0] == 2'b01 && rxd[0] == 1'b1, "R6 short pulse ignored", {mode[1:0], rxd[0]}, 3);

    bus[0] = 1'b0; step(WF);
    chk(mode[1:0] == 2'b10 && rxd[0] == 1'b0, "R6 remote wake", {mode[1:0], rxd[0]}, 4);
    bus[0] = 1'b1; step(2);
    chk(rxd[0] == 1'b0, "R6 wake request held", rxd[0], 0);

    slp_n[0] = 1'b1; step(GN);
    chk(mode[1:0] == 2'b11, "R7 normal clears wake", mode[1:0], 3);
    slp_n[0] = 1'b0; step(GS);
    chk(mode[1:0] == 2'b01 && rxd[0] == 1'b1, "R7 flag cleared", {mode[1:0], rxd[0]}, 3);

    slp_n[0] = 1'b1; step(GN);
    chk(mode[1:0] == 2'b11, "R7 local wake to normal", mode[1:0], 3);
    slp_n[0] = 1'b0; step(GS);
    bus[0] = 1'b0; step(1);
    slp_n[0] = 1'b1; step(GN);
    chk(mode[1:0] == 2'b11, "R7 local wins tie", mode[1:0], 3);
    bus[0] = 1'b1; step(1);

    slp_n[1] = 1'b0; step(GS);
    bus[1] = 1'b0; step(WF);
    bus[1] = 1'b1; step(1);
    chk(rxd[1] == 1'b0 && mode[3:2] == 2'b10, "R6 ch1 wake", {rxd[1], mode[3:2]}, 2);

    uv = 1'b1; step(1);
    chk(mode == 4'b0000 && txen == 2'b00, "R1 undervolt reset", {mode, txen}, 0);
    step(2);
    uv = 1'b0; step(1);
    chk(mode == 4'b1010 && rxd == 2'b11, "R1 release clears wake", {mode, rxd}, 43);
    step(GN + 2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule